// File: doc/BRIEF.md
# HI/LO Multiply Unit with Issue Interlock

This block is the multiply unit of an in-order pipeline's execute stage. It keeps two 32-bit result registers, HI and LO. It accepts six operations: a signed multiply, an unsigned multiply, a read of HI, a read of LO, a write of HI and a write of LO. A multiply takes a parameterised number of cycles. When it finishes, the upper half of the 64-bit product lands in HI and the lower half in LO.

While a multiply is still running, the unit cannot service any recognised operation. In that case it raises `stall` and leaves its state unchanged. The pipeline holds the instruction and presents it again, unchanged, on every cycle. The unit services it in the first cycle after the multiply retires. When the unit is idle, a multiply is accepted at once without a stall, and the unit then goes busy.

Top module: `hilo_mul_unit`

## Requirements
- R1: A synchronous reset clears HI, LO and the busy state, so a read of HI or LO right after reset returns 0 with `stall` low.
- R2: Opcode encoding on `opCode`: 0 signed multiply, 1 unsigned multiply, 2 read HI, 3 read LO, 4 write HI, 5 write LO. A multiply accepted while idle does not stall. For the next `LAT` cycles, every valid operation with opcode 0 to 5 raises `stall`.
- R3: A read of HI or LO that is stalled drives `rdData` to 0. When it is reissued in the first cycle after the multiply retires, it returns that multiply's result with `stall` low.
- R4: For opcode 0, the operands `srcA` and `srcB` are taken as two's complement. HI receives bits 63:32 of the product and LO receives bits 31:0.
- R5: For opcode 1, both operands are taken as unsigned.
- R6: Opcode 4 writes `srcA` into HI only, and opcode 5 writes `srcA` into LO only. Each write takes effect in the cycle it is accepted. Neither register changes at any other time except when a multiply retires.
- R7: A new multiply issued while a multiply is running stalls. It is started only once the unit is idle.
- R8: Opcodes 6 and 7, and any cycle with `opValid` low, never stall and change neither HI, LO nor the busy state.
- R9: `rdData` is 0 in every cycle that does not carry an accepted read of HI or LO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 3 | Operation code (see R2) |
| srcA | input | 32 | First multiply operand; data for HI/LO writes |
| srcB | input | 32 | Second multiply operand |
| rdData | output | 32 | HI or LO value for an accepted read, else 0 |
| stall | output | 1 | Operation cannot be serviced this cycle; reissue it |

## Verification
The bench aims at the retire boundary. It reissues a stalled read every cycle and expects the product in exactly the first idle cycle. A design whose busy window is one cycle short would return the old HI, and one that is one cycle long would stall once too often. It multiplies negative by positive and all-ones by all-ones, so a design that mixes up signed and unsigned extension, or swaps the product halves, gives a wrong HI. It issues writes, back-to-back multiplies and the two unused opcodes both during and after a multiply. This catches a unit that lets a write slip past the interlock, clobbers the other register, or stalls on codes it should ignore.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
  typedef enum logic [2:0] {
    OP_MUL_S = 3'd0,
    OP_MUL_U = 3'd1,
    OP_RD_HI = 3'd2,
    OP_RD_LO = 3'd3,
    OP_WR_HI = 3'd4,
    OP_WR_LO = 3'd5
  } hiloOp_e;

  typedef struct packed {
    logic capture;   // latch operands, start multiply
    logic isSigned;  // operands are two's complement
    logic retire;    // write product into HI/LO
    logic wrHi;
    logic wrLo;
    logic rdHi;
    logic rdLo;
  } hiloStrobe_t;
endpackage

// File: rtl/hilo_ctrl.sv
module hilo_ctrl
  import hilo_pkg::*;
#(
  parameter int unsigned LAT = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        opValid,
  input  logic [2:0]  opCode,
  output hiloStrobe_t strobe,
  output logic        stall
);
  localparam int unsigned CW = $clog2(LAT + 1);

  logic [CW-1:0] remainQ;
  logic          busy;
  logic          known;
  logic          accept;
  hiloOp_e       op;

  assign op     = hiloOp_e'(opCode);
  assign busy   = (remainQ != '0);
  assign known  = opValid && (opCode <= 3'd5);
  assign accept = known && !busy;
  assign stall  = known && busy;

  always_comb begin
    strobe          = '0;
    strobe.capture  = accept && ((op == OP_MUL_S) || (op == OP_MUL_U));
    strobe.isSigned = (op == OP_MUL_S);
    strobe.retire   = (remainQ == CW'(1));
    strobe.wrHi     = accept && (op == OP_WR_HI);
    strobe.wrLo     = accept && (op == OP_WR_LO);
    strobe.rdHi     = accept && (op == OP_RD_HI);
    strobe.rdLo     = accept && (op == OP_RD_LO);
  end

  always_ff @(posedge clk) begin
    if (rst)                 remainQ <= '0;
    else if (strobe.capture) remainQ <= CW'(LAT);
    else if (busy)           remainQ <= remainQ - CW'(1);
  end
endmodule

// File: rtl/hilo_dpath.sv
module hilo_dpath
  import hilo_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  hiloStrobe_t strobe,
  input  logic [W-1:0] srcA,
  input  logic [W-1:0] srcB,
  output logic [W-1:0] rdData,
  output logic [W-1:0] hiQ,
  output logic [W-1:0] loQ
);
  localparam int unsigned PW = 2 * W;

  logic [W-1:0]       opAQ, opBQ;
  logic               sgnQ;
  logic signed [W:0]  extA, extB;
  logic signed [PW+1:0] fullProd;
  logic [PW-1:0]      product;

  always_ff @(posedge clk) begin
    if (rst) begin
      opAQ <= '0;
      opBQ <= '0;
      sgnQ <= 1'b0;
    end else if (strobe.capture) begin
      opAQ <= srcA;
      opBQ <= srcB;
      sgnQ <= strobe.isSigned;
    end
  end

  // Product settles over the multi-cycle busy window.
  assign extA     = {sgnQ & opAQ[W-1], opAQ};
  assign extB     = {sgnQ & opBQ[W-1], opBQ};
  assign fullProd = extA * extB;
  assign product  = fullProd[PW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hiQ <= '0;
      loQ <= '0;
    end else begin
      if (strobe.retire)    hiQ <= product[PW-1:W];
      else if (strobe.wrHi) hiQ <= srcA;
      if (strobe.retire)    loQ <= product[W-1:0];
      else if (strobe.wrLo) loQ <= srcA;
    end
  end

  always_comb begin
    if (strobe.rdHi)      rdData = hiQ;
    else if (strobe.rdLo) rdData = loQ;
    else                  rdData = '0;
  end
endmodule

// File: rtl/hilo_mul_unit.sv
module hilo_mul_unit
  import hilo_pkg::*;
#(
  parameter int unsigned LAT = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        opValid,
  input  logic [2:0]  opCode,
  input  logic [31:0] srcA,
  input  logic [31:0] srcB,
  output logic [31:0] rdData,
  output logic        stall
);
  hiloStrobe_t strobe;
  logic [31:0] hiQ, loQ;

  hilo_ctrl #(.LAT(LAT)) ctrl (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .strobe(strobe), .stall(stall)
  );

  hilo_dpath #(.W(32)) dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .srcA(srcA), .srcB(srcB),
    .rdData(rdData), .hiQ(hiQ), .loQ(loQ)
  );
endmodule

// File: rtl/hilo_mul_chk.sv
module hilo_mul_chk #(
  parameter int unsigned LAT = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        opValid,
  input logic [2:0]  opCode,
  input logic [31:0] rdData,
  input logic        stall,
  input logic [31:0] hiQ,
  input logic [31:0] loQ
);
  int unsigned windowCnt;
  logic known, mulTaken, hiTaken, loTaken;

  assign known    = opValid && (opCode <= 3'd5);
  assign mulTaken = known && !stall && (opCode <= 3'd1);
  assign hiTaken  = known && !stall && (opCode == 3'd4);
  assign loTaken  = known && !stall && (opCode == 3'd5);

  always_ff @(posedge clk) begin
    if (rst)                 windowCnt <= 0;
    else if (mulTaken)       windowCnt <= LAT;
    else if (windowCnt != 0) windowCnt <= windowCnt - 1;
  end

  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (rst)
    (known && windowCnt != 0) |-> stall); // R2
  AST_STALL_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    stall |-> (windowCnt != 0)); // R7
  AST_UNKNOWN_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode > 3'd5) |-> !stall); // R8
  AST_HI_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(hiTaken || windowCnt == 1) |=> $stable(hiQ)); // R6
  AST_LO_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(loTaken || windowCnt == 1) |=> $stable(loQ)); // R6
  AST_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(opValid && (opCode == 3'd2 || opCode == 3'd3)) |-> (rdData == 32'd0)); // R9
  AST_STALLED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    stall |-> (rdData == 32'd0)); // R3
endmodule

bind hilo_mul_unit hilo_mul_chk #(.LAT(LAT)) chk (
  .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
  .rdData(rdData), .stall(stall), .hiQ(hiQ), .loQ(loQ)
);

// File: tb/tb_hilo_mul_unit.sv
`timescale 1ns/1ps
module tb_hilo_mul_unit;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [31:0] srcA = '0, srcB = '0;
  logic [31:0] rdData;
  logic        stall;

  int nVec = 0, nBad = 0;
  bit done = 0;

  // behavioural reference
  int          mBusy = 0;
  logic [31:0] mHi = '0, mLo = '0;
  logic [63:0] mPend = '0;
  bit          lastStall;

  always #2 clk = ~clk;

  hilo_mul_unit #(.LAT(LAT)) dut (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .rdData(rdData), .stall(stall)
  );

  task automatic step(input bit v, input logic [2:0] op,
                      input logic [31:0] a, input logic [31:0] b, input string tag);
    bit expStall;
    logic [31:0] expRd;
    opValid = v; opCode = op; srcA = a; srcB = b;
    expStall = v && (op <= 3'd5) && (mBusy > 0) && !rst;
    expRd = '0;
    if (v && !expStall && !rst && op == 3'd2) expRd = mHi;
    if (v && !expStall && !rst && op == 3'd3) expRd = mLo;
    @(negedge clk);
    nVec++;
    if (stall !== expStall || rdData !== expRd) begin
      nBad++;
      $display("FAIL %s: stall=%0b rdData=%h expected stall=%0b rdData=%h",
               tag, stall, rdData, expStall, expRd);
    end
    lastStall = expStall;
    @(posedge clk);
    if (rst) begin
      mBusy = 0; mHi = '0; mLo = '0;
    end else if (mBusy > 0) begin
      mBusy--;
      if (mBusy == 0) begin mHi = mPend[63:32]; mLo = mPend[31:0]; end
    end else if (v) begin
      case (op)
        3'd0: begin
          mPend = 64'(longint'($signed(a)) * longint'($signed(b)));
          mBusy = LAT;
        end
        3'd1: begin mPend = {32'd0, a} * {32'd0, b}; mBusy = LAT; end
        3'd4: mHi = a;
        3'd5: mLo = a;
        default: ;
      endcase
    end
    #1;
  endtask

  // reissue until the reference says the operation was accepted
  task automatic issue(input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    for (int k = 0; k < 20; k++) begin
      step(1'b1, op, a, b, tag);
      if (!lastStall) break;
    end
  endtask

  initial begin
    #(200000 * 4);
    nBad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    step(1'b0, 3'd0, '0, '0, "R1");
    step(1'b0, 3'd0, '0, '0, "R1");
    rst = 1'b0;
    issue(3'd2, '0, '0, "R1");
    issue(3'd3, '0, '0, "R1");
    // moves, each touching one register
    issue(3'd4, 32'hDEAD_BEEF, '0, "R6");
    issue(3'd3, '0, '0, "R6");
    issue(3'd5, 32'h1234_5678, '0, "R6");
    issue(3'd2, '0, '0, "R6");
    issue(3'd3, '0, '0, "R6");
    // signed multiply, reads reissued across busy window
    issue(3'd0, 32'hFFFF_FFFD, 32'd7, "R2");
    issue(3'd2, '0, '0, "R3");
    issue(3'd3, '0, '0, "R4");
    issue(3'd0, 32'h8000_0000, 32'h8000_0000, "R4");
    issue(3'd3, '0, '0, "R3");
    issue(3'd2, '0, '0, "R4");
    // unsigned
    issue(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5");
    issue(3'd2, '0, '0, "R5");
    issue(3'd3, '0, '0, "R5");
    // multiply reissued while busy
    issue(3'd1, 32'd3, 32'd5, "R7");
    issue(3'd0, 32'hFFFF_FFFF, 32'd2, "R7");
    issue(3'd2, '0, '0, "R7");
    issue(3'd3, '0, '0, "R7");
    // write during busy must wait
    issue(3'd1, 32'd100, 32'd100, "R2");
    issue(3'd4, 32'hAAAA_5555, '0, "R2");
    issue(3'd2, '0, '0, "R6");
    issue(3'd3, '0, '0, "R6");
    // unused codes and idle cycles, busy and not
    step(1'b1, 3'd6, 32'h1, 32'h1, "R8");
    step(1'b1, 3'd7, 32'h1, 32'h1, "R8");
    step(1'b0, 3'd2, '0, '0, "R9");
    issue(3'd0, 32'd9, 32'd9, "R8");
    step(1'b1, 3'd6, '0, '0, "R8");
    step(1'b1, 3'd7, '0, '0, "R8");
    step(1'b0, 3'd4, 32'h5, '0, "R8");
    step(1'b0, 3'd3, '0, '0, "R9");
    for (int k = 0; k < LAT; k++) step(1'b0, 3'd0, '0, '0, "R9");
    issue(3'd2, '0, '0, "R8");
    issue(3'd3, '0, '0, "R8");
    step(1'b1, 3'd4, 32'h0BAD_F00D, '0, "R9");
    step(1'b1, 3'd5, 32'hCAFE_0001, '0, "R9");
    issue(3'd2, '0, '0, "R6");
    issue(3'd3, '0, '0, "R6");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule